// File: doc/BRIEF.md
# Comparator Output Filter and Event Selector

This block conditions the one-bit decision of an analog comparator channel before it reaches a pin or the interrupt logic. The raw decision can first be inverted, to undo an exchange of the comparator's two inputs. The result then passes through a two-flop synchroniser into a short history register. A majority vote over the newest three or five history samples gives a filtered level. That level drives a status output and an edge detector, which raises one pulse per selected event.

The pin output takes one of three sources, selected by a routing code: nothing, the unsynchronised (inverted-if-swapped) bit, or the filtered level. A configuration flag warns when the filtered route is chosen but no filtering is active. While the channel enable is low, the synchroniser, the history and the edge detector are held cleared. After each enable, the filter therefore starts from an all-zero history.

Top module: `cmp_outproc`

## Requirements
- R1: The comparator bit is XORed with `swap` before any other use. With `route_sel` = 1 and `chan_en` = 1, `pin_out` equals `cmp_raw ^ swap` combinationally, with no clock delay.
- R2: When `flt_len` is 0 or any value from 3 to 7, no filtering is applied. `level_out` then equals the swapped bit as it was two clock edges earlier (two synchroniser flops).
- R3: When `flt_len` = 1, `level_out` is 1 when at least 2 of the 3 newest history samples are 1.
- R4: When `flt_len` = 2, `level_out` is 1 when at least 3 of the 5 newest history samples are 1.
- R5: `pin_out` is 0 for `route_sel` = 0, for `route_sel` = 3, and whenever `chan_en` = 0. For `route_sel` = 2 it equals `level_out`. For `route_sel` = 1 the filter setting has no effect on `pin_out`.
- R6: `cfg_bad` is 1 exactly when `route_sel` = 2 and `flt_len` is not 1 or 2.
- R7: `irq` is registered and is high in the cycle after the cycle in which `level_out` differs from its value at the previous edge, as follows. For `evt_sel` = 0 it fires on any difference. For `evt_sel` = 1 it fires only if the new level is 1. For `evt_sel` = 2 it fires only if the new level is 0.
- R8: For `evt_sel` = 3, `irq` is high in the cycle after each cycle with `eoc` = 1, but only while `one_shot` = 1. With `one_shot` = 0 it stays low. For `evt_sel` 0 to 2, `eoc` is ignored.
- R9: While `chan_en` = 0, `level_out`, `pin_out` and `irq` are 0. The synchroniser, history and previous-level registers are cleared. After reset the same holds.
- R10: A history sample (the second synchroniser flop) is shifted in only on edges where `smp_vld` = 1. Otherwise the history holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; low holds the datapath cleared |
| cmp_raw | input | 1 | Raw comparator decision |
| smp_vld | input | 1 | Sample strobe for the history register |
| swap | input | 1 | Invert the decision (inputs exchanged) |
| flt_len | input | 3 | 0 none, 1 two-of-three, 2 three-of-five, others none |
| route_sel | input | 2 | 0 off, 1 raw bit, 2 filtered level, 3 off |
| evt_sel | input | 2 | 0 toggle, 1 rising, 2 falling, 3 end of comparison |
| one_shot | input | 1 | Single-shot operation active |
| eoc | input | 1 | End-of-comparison strobe |
| pin_out | output | 1 | Routed pin output |
| level_out | output | 1 | Filtered comparator level |
| irq | output | 1 | Interrupt/event pulse |
| cfg_bad | output | 1 | Filtered route selected without filtering |

## Verification
The hardest state to reach is a change of the voted level that comes from a partly filled or partly stale history. This happens when sparse sample strobes mix with a recent re-enable or a change of filter length during operation. The stimulus reaches it with many short configuration epochs. Each epoch draws random raw bits, sample strobes with varying density, end-of-comparison strobes and occasional enable drops. A behavioural model checks every output on every clock. Two directed sequences pin down the held history and the combinational raw route.

// File: rtl/cmp_outproc_pkg.sv
package cmp_outproc_pkg;

  typedef enum logic [1:0] {
    ROUTE_OFF  = 2'd0,
    ROUTE_RAW  = 2'd1,
    ROUTE_FILT = 2'd2,
    ROUTE_RSVD = 2'd3
  } route_e;

  typedef enum logic [1:0] {
    EV_TOGGLE = 2'd0,
    EV_RISE   = 2'd1,
    EV_FALL   = 2'd2,
    EV_DONE   = 2'd3
  } event_e;

  localparam logic [2:0] FLT_MAJ3 = 3'd1;
  localparam logic [2:0] FLT_MAJ5 = 3'd2;

  // Window size for a filter code; 0 means pass-through.
  function automatic int unsigned win_of(input logic [2:0] code);
    case (code)
      FLT_MAJ3: win_of = 3;
      FLT_MAJ5: win_of = 5;
      default:  win_of = 0;
    endcase
  endfunction

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    if (clr) begin
      chain_d = '0;
    end else begin
      chain_d = {chain_q[STAGES-2:0], d};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

  // R9
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (chain_q == '0));

endmodule

// File: rtl/cmp_maj_filter.sv
module cmp_maj_filter
  import cmp_outproc_pkg::*;
#(
  parameter int HIST_LEN = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       shift_en,
  input  logic       din,
  input  logic [2:0] flt_len,
  output logic       dout
);

  localparam int CNT_W = $clog2(HIST_LEN + 1);

  logic [HIST_LEN-1:0] hist_q;
  logic [HIST_LEN-1:0] hist_d;
  logic [HIST_LEN-1:0] win_mask;
  logic [CNT_W-1:0]    ones;
  logic [CNT_W-1:0]    thresh;
  int unsigned         win;

  // History: bit 0 is the newest sample.
  always_comb begin
    hist_d = hist_q;
    if (clr) begin
      hist_d = '0;
    end else if (shift_en) begin
      hist_d = {hist_q[HIST_LEN-2:0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

  // Window mask and population count.
  always_comb begin
    win = win_of(flt_len);
    for (int i = 0; i < HIST_LEN; i++) begin
      win_mask[i] = (i < int'(win));
    end
    ones = '0;
    for (int i = 0; i < HIST_LEN; i++) begin
      ones = ones + CNT_W'(hist_q[i] & win_mask[i]);
    end
    thresh = CNT_W'((win / 2) + 1);
  end

  always_comb begin
    if (win == 0) begin
      dout = din;
    end else begin
      dout = (ones >= thresh);
    end
  end

  // R9
  hist_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hist_q == '0));

  // R10
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !shift_en) |=> $stable(hist_q));

endmodule

// File: rtl/cmp_event_gen.sv
module cmp_event_gen
  import cmp_outproc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       level,
  input  logic [1:0] evt_sel,
  input  logic       one_shot,
  input  logic       eoc,
  output logic       irq
);

  logic   prev_q, prev_d;
  logic   irq_q, irq_d;
  logic   ev;
  event_e sel;

  assign sel = event_e'(evt_sel);

  always_comb begin
    case (sel)
      EV_TOGGLE: ev = level ^ prev_q;
      EV_RISE:   ev = level & ~prev_q;
      EV_FALL:   ev = ~level & prev_q;
      default:   ev = eoc & one_shot;
    endcase
  end

  always_comb begin
    if (clr) begin
      prev_d = 1'b0;
      irq_d  = 1'b0;
    end else begin
      prev_d = level;
      irq_d  = ev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      irq_q  <= irq_d;
    end
  end

  assign irq = irq_q;

  // R7
  rise_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && sel == EV_RISE && level && !prev_q) |=> irq);

  // R7
  fall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && sel == EV_FALL && level) |=> !irq);

  // R8
  done_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == EV_DONE && !one_shot) |=> !irq);

endmodule

// File: rtl/cmp_outproc.sv
module cmp_outproc
  import cmp_outproc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HIST_LEN    = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_en,
  input  logic       cmp_raw,
  input  logic       smp_vld,
  input  logic       swap,
  input  logic [2:0] flt_len,
  input  logic [1:0] route_sel,
  input  logic [1:0] evt_sel,
  input  logic       one_shot,
  input  logic       eoc,
  output logic       pin_out,
  level_out,
  output logic       irq,
  output logic       cfg_bad
);

  logic   bit_adj;
  logic   bit_sync;
  logic   filt;
  logic   clr;
  route_e route;

  assign clr     = ~chan_en;
  assign bit_adj = cmp_raw ^ swap;
  assign route   = route_e'(route_sel);

  cmp_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .d     (bit_adj),
    .q     (bit_sync)
  );

  cmp_maj_filter #(
    .HIST_LEN(HIST_LEN)
  ) u_filt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .shift_en (smp_vld),
    .din      (bit_sync),
    .flt_len  (flt_len),
    .dout     (filt)
  );

  assign level_out = chan_en & filt;

  cmp_event_gen u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .level    (level_out),
    .evt_sel  (evt_sel),
    .one_shot (one_shot),
    .eoc      (eoc),
    .irq      (irq)
  );

  always_comb begin
    pin_out = 1'b0;
    if (chan_en) begin
      case (route)
        ROUTE_RAW:  pin_out = bit_adj;
        ROUTE_FILT: pin_out = level_out;
        default:    pin_out = 1'b0;
      endcase
    end
  end

  assign cfg_bad = (route == ROUTE_FILT) && (win_of(flt_len) == 0);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (!irq || chan_en));

  // R5
  pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route == ROUTE_OFF || route == ROUTE_RSVD) |-> !pin_out);

endmodule

// File: tb/tb_cmp_outproc.sv
module tb_cmp_outproc;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       chan_en, cmp_raw, smp_vld, swap, one_shot, eoc;
  logic [2:0] flt_len;
  logic [1:0] route_sel, evt_sel;
  logic       pin_out, level_out, irq, cfg_bad;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cmp_outproc dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cmp_raw(cmp_raw),
    .smp_vld(smp_vld), .swap(swap), .flt_len(flt_len),
    .route_sel(route_sel), .evt_sel(evt_sel), .one_shot(one_shot),
    .eoc(eoc), .pin_out(pin_out), .level_out(level_out), .irq(irq),
    .cfg_bad(cfg_bad)
  );

  // Behavioural reference: newest sample at index 0.
  bit m_s1, m_s2, m_prev, m_irq;
  bit m_hist[5];

  function automatic bit m_level();
    int w, n;
    if (!chan_en) return 1'b0;
    w = (flt_len == 3'd1) ? 3 : (flt_len == 3'd2) ? 5 : 0;
    if (w == 0) return m_s2;
    n = 0;
    for (int i = 0; i < w; i++) n += m_hist[i];
    return n >= (w / 2 + 1);
  endfunction

  task automatic m_clear();
    m_s1 = 0; m_s2 = 0; m_prev = 0; m_irq = 0;
    for (int i = 0; i < 5; i++) m_hist[i] = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !chan_en) begin
      m_clear();
    end else begin
      bit st;
      st = m_level();
      case (evt_sel)
        2'd0: m_irq = st != m_prev;
        2'd1: m_irq = st && !m_prev;
        2'd2: m_irq = !st && m_prev;
        default: m_irq = eoc && one_shot;
      endcase
      m_prev = st;
      if (smp_vld) begin
        for (int i = 4; i > 0; i--) m_hist[i] = m_hist[i-1];
        m_hist[0] = m_s2;
      end
      m_s2 = m_s1;
      m_s1 = cmp_raw ^ swap;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge.
  always @(posedge clk) begin
    #2;
    if (!done) begin
      bit el, ep, ec;
      string lt, pt, it;
      el = m_level();
      ep = !chan_en ? 1'b0 : (route_sel == 2'd1) ? (cmp_raw ^ swap) :
           (route_sel == 2'd2) ? el : 1'b0;
      ec = (route_sel == 2'd2) && !(flt_len == 3'd1 || flt_len == 3'd2);
      lt = !chan_en ? "R9" : (flt_len == 3'd1) ? "R3" : (flt_len == 3'd2) ? "R4" : "R2";
      pt = (route_sel == 2'd1 && chan_en) ? "R1" : "R5";
      it = (evt_sel == 2'd3) ? "R8" : "R7";
      check(level_out == el, {lt, " level"}, level_out, el);
      check(pin_out == ep, {pt, " pin"}, pin_out, ep);
      check(irq == m_irq, {it, " irq"}, irq, m_irq);
      check(cfg_bad == ec, "R6 cfg_bad", cfg_bad, ec);
    end
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; chan_en = 0; cmp_raw = 0; smp_vld = 0; swap = 0;
    one_shot = 0; eoc = 0; flt_len = 0; route_sel = 0; evt_sel = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(level_out == 0 && pin_out == 0 && irq == 0, "R9 reset", irq, 0);
    rst_n = 1;
    @(negedge clk);

    // Unfiltered, filtered route, toggle events.
    chan_en = 1; route_sel = 2; smp_vld = 1;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      cmp_raw = $urandom_range(0, 1);
    end

    // R1 directed: raw route is combinational and inverted by swap.
    route_sel = 1; swap = 1; cmp_raw = 0; flt_len = 2;
    #1;
    check(pin_out == 1, "R1 swap raw route", pin_out, 1);

    // R10 directed: history holds without strobes.
    swap = 0; route_sel = 2; cmp_raw = 1; smp_vld = 1;
    repeat (10) @(negedge clk);
    smp_vld = 0; cmp_raw = 0;
    repeat (12) @(negedge clk);
    check(level_out == 1, "R10 history held", level_out, 1);
    smp_vld = 1;

    // Random configuration epochs.
    for (int e = 0; e < 60; e++) begin
      int dens;
      @(negedge clk);
      flt_len   = $urandom_range(0, 7);
      if ($urandom_range(0, 2) != 0) flt_len = $urandom_range(1, 2);
      route_sel = $urandom_range(0, 3);
      evt_sel   = $urandom_range(0, 3);
      swap      = $urandom_range(0, 1);
      one_shot  = $urandom_range(0, 1);
      dens      = $urandom_range(1, 4);
      for (int c = 0; c < 120; c++) begin
        @(negedge clk);
        cmp_raw = ($urandom_range(0, 7) < 2) ? ~cmp_raw : cmp_raw;
        smp_vld = ($urandom_range(1, 4) <= dens);
        eoc     = ($urandom_range(0, 9) == 0);
        chan_en = ($urandom_range(0, 59) != 0);
      end
    end

    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule